// File: doc/BRIEF.md
# Handshaked Special-Register Bus Slave

This block is a small register slave on an 8-bit processor bus. It watches the shared address bus for direct-mode accesses to its two addresses in the upper special-register window. It completes each processor read or write with a four-phase request/acknowledge exchange. The bus controller raises a read or write strobe and waits for the acknowledge. It then drops the strobe, and the block drops the acknowledge in turn.

The block holds a control register and a data register at adjacent addresses. Bit 0 of the control register claims one shared port pin through a select output. While the pin is claimed, bit 0 of the data register appears on the pin's data line. The bidirectional data bus is split into a write-data input, a read-data output and a read-data output enable. When the indirect-addressing flag is high, the block treats the access as one to some other address.

Top module: `sfr_bus_slave`

## Requirements
- R1: Only addresses 0x98 (control register) and 0x99 (data register) with the indirect flag at 0 are served. Any other address gives no acknowledge, no read-data enable and no register change.
- R2: While `bus_indirect` is 1, an access to 0x98 or 0x99 is ignored: no acknowledge, no read-data enable, and the registers keep their values.
- R3: A write is taken on the first clock edge at which `bus_wr` is seen newly high with a matching address. The register takes `bus_wdata` at that edge, and `bus_ack` is 1 from that edge on.
- R4: `bus_rdata_oe` is 1, in the same cycle and without a clock, exactly while `bus_rd` is 1, `bus_wr` is 0 and the address matches. `bus_rdata` then carries the selected register and is 0x00 otherwise. `bus_ack` rises at the first clock edge of a matching read.
- R5: Once `bus_ack` is 1, it stays 1 while either strobe is high. It falls at the first clock edge at which both strobes are seen low.
- R6: Each write strobe assertion writes at most once. Changes on `bus_wdata` while the strobe stays high are not captured.
- R7: `pin_sel` equals control bit 0. `pin_dout` equals data bit 0 while `pin_sel` is 1 and is 0 otherwise.
- R8: If `bus_rd` and `bus_wr` are high together, there is no write, no acknowledge and no read-data enable. A strobe left high after the other one drops does not start an access either.
- R9: Reset (`rst_n` low) clears both registers and `bus_ack` to 0. `pin_sel`, `pin_dout` and `bus_rdata_oe` are then 0.
- R10: An access starts only on a strobe's rising edge. A strobe already high when the address changes to a matching one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Bus address |
| bus_indirect | input | 1 | 1 when the access uses indirect addressing |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Read strobe from the bus controller |
| bus_wr | input | 1 | Write strobe from the bus controller |
| bus_rdata | output | 8 | Read data toward the bus |
| bus_rdata_oe | output | 1 | Read-data drive enable |
| bus_ack | output | 1 | Access acknowledge |
| pin_sel | output | 1 | 1 while the block owns the shared pin |
| pin_dout | output | 1 | Data for the shared pin |

## Verification
The in-RTL assertions check on every cycle that the acknowledge is held and released by the strobe levels. They also check that conflicting strobes or an unmatched address never raise it, that a write pulse never lasts two cycles, and that the read enable never appears without a direct read. The bench's scenarios are needed to show the register values that reads return after a sequence of writes. They also show that writes to indirect or neighbouring addresses leave those values unchanged, that data changed during a held strobe is dropped, and that a strobe raised before the address matched is ignored.

// File: rtl/sfr_slave_pkg.sv
package sfr_slave_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_ACK  = 1'b1
  } hs_state_e;

  localparam int unsigned CTRL_IDX = 0;
  localparam int unsigned DATA_IDX = 1;
endpackage

// File: rtl/sfr_addr_decode.sv
module sfr_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_REGS  = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h98
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                indirect,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_sel
      localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(gi);
      assign sel[gi] = !indirect && (addr == MY_ADDR);
    end
  endgenerate

  assign hit = |sel;

  assert_indirect_nohit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    indirect |-> !hit);
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/sfr_handshake.sv
module sfr_handshake
  import sfr_slave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic wr,
  input  logic hit,
  output logic ack,
  output logic wr_pulse
);
  hs_state_e state_q, state_d;
  logic      rd_q, wr_q;
  logic      rd_rise, wr_rise, conflict, start;

  assign rd_rise  = rd && !rd_q;
  assign wr_rise  = wr && !wr_q;
  assign conflict = rd && wr;
  assign start    = (state_q == HS_IDLE) && hit && !conflict && (rd_rise || wr_rise);

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_IDLE: if (start) state_d = HS_ACK;
      HS_ACK:  if (!rd && !wr) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd;
      wr_q    <= wr;
    end
  end

  assign wr_pulse = start && wr;
  assign ack      = (state_q == HS_ACK);

  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (rd || wr)) |=> ack);
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rd && !wr) |=> !ack);
  assert_conflict_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr && !ack) |=> !ack);
  assert_nohit_noack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !hit) |=> !ack);
  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/sfr_regbank.sv
module sfr_regbank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [NUM_REGS-1:0]        sel,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          rdata_mux
);
  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic [DATA_W-1:0] reg_d [NUM_REGS];
  logic [NUM_REGS-1:0] reg_en;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      assign reg_en[gi] = we && sel[gi];

      always_comb begin
        reg_d[gi] = reg_q[gi];
        if (reg_en[gi]) reg_d[gi] = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q[gi] <= '0;
        else        reg_q[gi] <= reg_d[gi];
      end

      assign regs_flat[gi*DATA_W +: DATA_W] = reg_q[gi];

      assert_write_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en[gi] |=> (reg_q[gi] == $past(wdata)));
      assert_no_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en[gi] |=> $stable(reg_q[gi]));
    end
  endgenerate

  always_comb begin
    rdata_mux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rdata_mux = rdata_mux | reg_q[i];
    end
  end
endmodule

// File: rtl/sfr_bus_slave.sv
module sfr_bus_slave
  import sfr_slave_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h98,
  parameter int unsigned SEL_BIT  = 0,
  parameter int unsigned PIN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_indirect,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic              bus_ack,
  output logic              pin_sel,
  output logic              pin_dout
);
  localparam int unsigned NUM_REGS = 2;

  logic                       rst_meta_q, rst_sync_q;
  logic [NUM_REGS-1:0]        sel;
  logic                       hit;
  logic                       wr_pulse;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]          rdata_mux;
  logic [DATA_W-1:0]          ctrl_val, data_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sfr_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_sync_q), .addr(bus_addr), .indirect(bus_indirect),
    .sel(sel), .hit(hit)
  );

  sfr_handshake u_hs (
    .clk(clk), .rst_n(rst_sync_q), .rd(bus_rd), .wr(bus_wr), .hit(hit),
    .ack(bus_ack), .wr_pulse(wr_pulse)
  );

  sfr_regbank #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .we(wr_pulse), .sel(sel), .wdata(bus_wdata),
    .regs_flat(regs_flat), .rdata_mux(rdata_mux)
  );

  assign ctrl_val     = regs_flat[CTRL_IDX*DATA_W +: DATA_W];
  assign data_val     = regs_flat[DATA_IDX*DATA_W +: DATA_W];
  assign bus_rdata_oe = bus_rd && !bus_wr && hit;
  assign bus_rdata    = bus_rdata_oe ? rdata_mux : '0;
  assign pin_sel      = ctrl_val[SEL_BIT];
  assign pin_dout     = pin_sel && data_val[PIN_BIT];

  assert_oe_direct_read_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bus_rdata_oe |-> (bus_rd && !bus_wr && !bus_indirect));
  assert_pin_sel_stable_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$past(wr_pulse) |-> $stable(pin_sel));
  assert_ack_direct_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(bus_ack) |-> !$past(bus_indirect));
endmodule

// File: tb/sfr_bus_slave_tb_top.sv
module sfr_bus_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_indirect, bus_rd, bus_wr, bus_rdata_oe, bus_ack, pin_sel, pin_dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] ctrl_m, data_m;

  always #2 clk = ~clk;

  sfr_bus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_indirect(bus_indirect),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .bus_ack(bus_ack), .pin_sel(pin_sel), .pin_dout(pin_dout)
  );

  // {is_write, indirect, addr, data, expect_ack}
  localparam logic [18:0] VEC [14] = '{
    {1'b1, 1'b0, 8'h98, 8'h01, 1'b1},
    {1'b1, 1'b0, 8'h99, 8'hA5, 1'b1},
    {1'b0, 1'b0, 8'h98, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h99, 8'h00, 1'b1},
    {1'b1, 1'b1, 8'h99, 8'h3C, 1'b0},
    {1'b0, 1'b1, 8'h99, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h97, 8'hFF, 1'b0},
    {1'b1, 1'b0, 8'h9A, 8'hFF, 1'b0},
    {1'b0, 1'b0, 8'h9A, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h99, 8'h5A, 1'b1},
    {1'b0, 1'b0, 8'h99, 8'h00, 1'b1},
    {1'b1, 1'b0, 8'h98, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h98, 8'h00, 1'b1},
    {1'b1, 1'b0, 8'h18, 8'hEE, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic idle_bus();
    bus_rd = 0; bus_wr = 0; bus_indirect = 0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic check_pin(input string req);
    chk(req, {7'd0, pin_sel}, {7'd0, ctrl_m[0]});
    chk(req, {7'd0, pin_dout}, {7'd0, ctrl_m[0] & data_m[0]});
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    return (a == 8'h98) ? ctrl_m : data_m;
  endfunction

  task automatic access(input bit is_wr, input bit ind, input logic [7:0] a,
                        input logic [7:0] d, input bit exp_ack, input string req);
    @(negedge clk);
    bus_addr = a; bus_indirect = ind; bus_wdata = d;
    bus_wr = is_wr; bus_rd = !is_wr;
    #1;
    if (!is_wr) begin
      chk({req, " R4 oe"}, {7'd0, bus_rdata_oe}, {7'd0, exp_ack});
      chk({req, " R4 rdata"}, bus_rdata, exp_ack ? model_rd(a) : 8'h00);
    end
    @(posedge clk); #1;
    chk({req, " ack"}, {7'd0, bus_ack}, {7'd0, exp_ack});
    repeat (2) @(posedge clk);
    #1 chk({req, " R5 ack held"}, {7'd0, bus_ack}, {7'd0, exp_ack});
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    #1 chk({req, " R4 oe after strobe"}, {7'd0, bus_rdata_oe}, 8'h00);
    @(posedge clk); #1;
    chk({req, " R5 ack released"}, {7'd0, bus_ack}, 8'h00);
    if (is_wr && exp_ack) begin
      if (a == 8'h98) ctrl_m = d; else data_m = d;
    end
    check_pin("R7 pin");
  endtask

  task automatic read_expect(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_indirect = 0; bus_rd = 1; bus_wr = 0;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    ctrl_m = 0; data_m = 0;
  endtask

  initial begin
    idle_bus();
    ctrl_m = 0; data_m = 0;
    rst_n = 0;
    #1;
    chk("R9 reset ack", {7'd0, bus_ack}, 8'h00);
    chk("R9 reset pin_sel", {7'd0, pin_sel}, 8'h00);
    chk("R9 reset pin_dout", {7'd0, pin_dout}, 8'h00);
    do_reset();
    chk("R9 oe idle", {7'd0, bus_rdata_oe}, 8'h00);
    chk("R9 rdata idle", bus_rdata, 8'h00);

    for (int i = 0; i < 14; i++) begin
      automatic logic [18:0] v = VEC[i];
      automatic string tag;
      if (v[17])      tag = "R2 indirect";
      else if (!v[0]) tag = "R1 decode";
      else if (v[18]) tag = "R3 write";
      else            tag = "R4 read";
      access(v[18], v[17], v[16:9], v[8:1], v[0], tag);
    end
    read_expect(8'h99, data_m, "R2 R1 data reg untouched");
    read_expect(8'h98, ctrl_m, "R1 ctrl reg untouched");

    // R6: data changed during a held write strobe is not captured
    @(negedge clk);
    bus_addr = 8'h99; bus_wdata = 8'h11; bus_wr = 1;
    @(negedge clk) bus_wdata = 8'h22;
    repeat (3) @(negedge clk);
    bus_wr = 0;
    @(posedge clk); #1;
    data_m = 8'h11;
    read_expect(8'h99, 8'h11, "R6 single capture");

    // R8: both strobes high together
    @(negedge clk);
    bus_addr = 8'h98; bus_wdata = 8'h81; bus_wr = 1; bus_rd = 1;
    #1 chk("R8 conflict oe", {7'd0, bus_rdata_oe}, 8'h00);
    @(posedge clk); #1 chk("R8 conflict ack", {7'd0, bus_ack}, 8'h00);
    @(negedge clk) bus_rd = 0;
    repeat (2) @(posedge clk);
    #1 chk("R8 leftover strobe no ack", {7'd0, bus_ack}, 8'h00);
    @(negedge clk) bus_wr = 0;
    @(posedge clk); #1;
    read_expect(8'h98, ctrl_m, "R8 conflict no write");

    // R10: strobe raised on a foreign address, then address moves to ours
    @(negedge clk);
    bus_addr = 8'h50; bus_wdata = 8'h77; bus_wr = 1;
    repeat (2) @(negedge clk);
    bus_addr = 8'h99;
    repeat (2) @(posedge clk);
    #1 chk("R10 no ack without rising edge", {7'd0, bus_ack}, 8'h00);
    @(negedge clk) bus_wr = 0;
    @(posedge clk); #1;
    read_expect(8'h99, data_m, "R10 no write without rising edge");

    // R7: claim pin with data bit 0 set, then reset clears all (R9)
    access(1, 0, 8'h99, 8'h03, 1, "R3 write data");
    access(1, 0, 8'h98, 8'h01, 1, "R3 write ctrl");
    chk("R7 pin_dout driven", {7'd0, pin_dout}, 8'h01);
    do_reset();
    chk("R9 pin_sel after reset", {7'd0, pin_sel}, 8'h00);
    read_expect(8'h98, 8'h00, "R9 ctrl cleared");
    read_expect(8'h99, 8'h00, "R9 data cleared");

    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule